// File: doc/BRIEF.md
# I2C Register Slave Front End

This block lets an I2C bus master read and write a small register file of ten bytes. The block samples the bus clock and data lines on a fast system clock. It detects START, repeated START and STOP conditions and answers only to its own 7-bit device address. Every byte it accepts is acknowledged. The data line is never driven high: the block raises an output enable, and the pad pulls the line low while that enable is set.

A write transaction always begins by loading the register pointer from the first byte after the address. Each data byte that follows is stored at the pointer, and the pointer then advances by one, wrapping from the last register back to zero. A read transaction starts at the current pointer and streams successive registers for as long as the master acknowledges. A pointer write followed by a repeated START and a read returns data from the chosen register.

The register file sits outside the block and is reached through a plain byte port. The address is always presented and read data is taken combinationally. A write strobe lasts one cycle. The bus cannot be stretched, so this port has no back-pressure: the register file must accept a write and return read data in the same cycle.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe` = 0), issues no write (`reg_wr_en` = 0) and presents register 0 on `reg_addr`.
- R2: An address byte whose upper seven bits equal 68h (byte D0h to write, D1h to read, bit 0 = 1 meaning read) is acknowledged by driving the data line low during the ninth clock. Any other address gets no acknowledge, and no byte of that transaction is acknowledged or written.
- R3: In a write transaction the first byte after the address loads the pointer. Each later byte is written to the pointer address and then advances the pointer, and every received byte is acknowledged.
- R4: The pointer advances from 9 to 0, on both writes and reads, and `reg_addr` never exceeds 9.
- R5: In a read transaction bits go out MSB first. Successive bytes come from successive registers starting at the pointer. The data line changes only while SCL is low, and after the master does not acknowledge a byte the block releases the line and sends nothing more.
- R6: A repeated START without a preceding STOP begins a new transaction and keeps the pointer, so a pointer write followed by a read returns data from that pointer.
- R7: A STOP at any point ends the transaction and releases the data line. A partially received byte is never written.
- R8: A pointer byte of value 10 or more loads the pointer with 0.
- R9: Each stored data byte produces exactly one single-cycle `reg_wr_en` pulse, and that byte's acknowledge starts on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 4 | Register address for both read and write |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Byte held at `reg_addr`, combinational |

## Verification
A wrong protocol state shows on the bus within one byte. A missing or spurious acknowledge appears on the ninth clock of the byte in which the state went wrong. A read shifted by a bit or taken from the wrong register shows up as a wrong byte value on the very next read. A pointer error cannot be seen at once. It appears when the register file is read back, or on the next write, as a byte stored at or returned from the neighbouring address, and wrap errors only at the 9-to-0 boundary.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WORD,
    ST_WDATA,
    ST_ACK,
    ST_READ,
    ST_MACK
  } i2cs_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
  parameter int NUM_REGS = 10,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  localparam logic [7:0]    NUM_B = 8'(NUM_REGS);
  localparam logic [AW-1:0] LAST  = AW'(NUM_REGS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= (load_val < NUM_B) ? load_val[AW-1:0] : '0;
    end else if (inc) begin
      ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
    end
  end

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_REGS);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NUM_REGS    = 10,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [7:0]    reg_wr_data,
  input  logic [7:0]    reg_rd_data
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_cond, stop_cond;
  i2cs_state_t state, ret_state;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic       byte_done;
  logic       mst_ack;
  logic       ptr_load, ptr_inc, wr_fire, load_byte, bus_evt;
  logic [AW-1:0] ptr;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .q_out ({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_cond (start_cond),
    .stop_cond  (stop_cond)
  );

  i2cs_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (shreg),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  always_comb begin
    bus_evt   = ~start_cond & ~stop_cond & scl_fall;
    ptr_load  = bus_evt & byte_done & (state == ST_WORD);
    wr_fire   = bus_evt & byte_done & (state == ST_WDATA);
    load_byte = bus_evt & (((state == ST_ACK) && (ret_state == ST_READ)) ||
                           ((state == ST_MACK) && mst_ack));
    ptr_inc   = wr_fire | load_byte;
  end

  assign reg_addr    = ptr;
  assign reg_wr_en   = wr_fire;
  assign reg_wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      mst_ack   <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (start_cond) begin
      state     <= ST_ADDR;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_cond) begin
      state     <= ST_IDLE;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            shreg     <= {shreg[6:0], sda_s};
            bit_cnt   <= bit_cnt + 4'd1;
            byte_done <= (bit_cnt == 4'd7);
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            bit_cnt   <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                ret_state <= shreg[0] ? ST_READ : ST_WORD;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              ret_state <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (ret_state == ST_READ) begin
              shreg  <= reg_rd_data;
              sda_oe <= ~reg_rd_data[7];
              state  <= ST_READ;
            end else begin
              sda_oe <= 1'b0;
              state  <= ret_state;
            end
          end
        end
        ST_READ: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (mst_ack) begin
              shreg   <= reg_rd_data;
              sda_oe  <= ~reg_rd_data[7];
              bit_cnt <= '0;
              state   <= ST_READ;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_cond) && !$past(stop_cond)) |-> $stable(sda_oe));

  // R9
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R9
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> sda_oe);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cond |=> !sda_oe);
endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] reg_addr;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;
  logic [7:0] mem [10];
  logic       sda_line;
  int checks = 0;
  int errors = 0;
  int wr_pulses = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign reg_rd_data = mem[reg_addr];

  i2c_reg_slave u_i2c_reg_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_m),
    .sda_in      (sda_line),
    .sda_oe      (sda_oe),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) mem[i] <= 8'h10 + 8'(i);
    end else if (reg_wr_en) begin
      mem[reg_addr] <= reg_wr_data;
    end
  end

  always @(posedge clk) if (reg_wr_en) wr_pulses++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(reg_wr_en == 1'b0, "R1 wr_en", reg_wr_en, 0);
    check(reg_addr == 4'd0, "R1 reg_addr", reg_addr, 0);
  endtask

  task automatic t_write_basic();
    logic a0, a1, a2, a3, a4;
    int p0;
    p0 = wr_pulses;
    bus_start();
    send_byte(8'hD0, a0);
    send_byte(8'h02, a1);
    send_byte(8'hA1, a2);
    send_byte(8'hB2, a3);
    send_byte(8'hC3, a4);
    bus_stop();
    check(a0, "R2 addr ack", a0, 1);
    check(a1 && a2 && a3 && a4, "R3 byte acks", {a1, a2, a3, a4}, 4'hF);
    check(mem[2] == 8'hA1, "R3 mem2", mem[2], 8'hA1);
    check(mem[3] == 8'hB2, "R3 mem3", mem[3], 8'hB2);
    check(mem[4] == 8'hC3, "R3 mem4", mem[4], 8'hC3);
    check(mem[1] == 8'h11, "R3 mem1 untouched", mem[1], 8'h11);
    check(wr_pulses - p0 == 3, "R9 pulse count", wr_pulses - p0, 3);
    check(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
  endtask

  task automatic t_read_seq();
    logic a0, a1, a2, s;
    logic [7:0] b0, b1, b2, b3;
    bus_start();
    send_byte(8'hD0, a0);
    send_byte(8'h02, a1);
    bus_rstart();
    send_byte(8'hD1, a2);
    check(a2, "R6 read addr ack after rstart", a2, 1);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b0, b2);
    check(b0 == 8'hA1, "R6 first read byte", b0, 8'hA1);
    check(b1 == 8'hB2, "R5 second read byte", b1, 8'hB2);
    check(b2 == 8'hC3, "R5 third read byte", b2, 8'hC3);
    check(sda_oe == 1'b0, "R5 released after nack", sda_oe, 0);
    recv_byte(1'b0, b3);
    check(b3 == 8'hFF, "R5 silent after nack", b3, 8'hFF);
    bus_stop();
    s = a0 & a1;
    check(s, "R3 pointer write acks", s, 1);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1, a2;
    int p0;
    p0 = wr_pulses;
    bus_start();
    send_byte(8'hA0, a0);
    send_byte(8'h03, a1);
    send_byte(8'h55, a2);
    bus_stop();
    check(!a0, "R2 foreign addr nack", a0, 0);
    check(!a1 && !a2, "R2 later bytes nack", {a1, a2}, 0);
    check(mem[3] == 8'hB2, "R2 mem3 unchanged", mem[3], 8'hB2);
    check(wr_pulses == p0, "R2 no write", wr_pulses - p0, 0);
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] b0, b1, b2;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h09, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop();
    check(mem[9] == 8'h11, "R4 mem9", mem[9], 8'h11);
    check(mem[0] == 8'h22, "R4 write wrap to 0", mem[0], 8'h22);
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h08, a);
    bus_rstart();
    send_byte(8'hD1, a);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b0, b2);
    bus_stop();
    check(b0 == 8'h18, "R4 read mem8", b0, 8'h18);
    check(b1 == 8'h11, "R4 read mem9", b1, 8'h11);
    check(b2 == 8'h22, "R4 read wrap mem0", b2, 8'h22);
  endtask

  task automatic t_bad_word();
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD0, a0);
    send_byte(8'h0C, a1);
    send_byte(8'h77, a2);
    bus_stop();
    check(a1 && a2, "R8 acks", {a1, a2}, 2'b11);
    check(mem[0] == 8'h77, "R8 out of range loads 0", mem[0], 8'h77);
  endtask

  task automatic t_stop_partial();
    logic a, s;
    logic [7:0] b;
    int p0;
    p0 = wr_pulses;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h05, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    bus_stop();
    check(mem[5] == 8'h15, "R7 partial not written", mem[5], 8'h15);
    check(wr_pulses == p0, "R7 no strobe", wr_pulses - p0, 0);
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h15, "R7 next transaction reads pointer", b, 8'h15);
  endtask

  initial begin
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write_basic();
    t_read_seq();
    t_wrong_addr();
    t_wrap();
    t_bad_word();
    t_stop_partial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule